// File: doc/BRIEF.md
# Network-Side Loop Activation Controller

This block decides which information state the network end of a basic-rate S/T loop puts on the line. There are three. The first is idle (INFO 0): every bit is sent as binary one, which means no line signal. The second is wake-up/acknowledge (INFO 2): all channel bits and the A bit are sent as zero. The third is fully operational (INFO 4): the B1, B2, D and E data is live and the A bit is one. A framer asks for one bit slot at a time by presenting a slot code. The block answers at once on `tx_bit`, according to its current state and the channel data offered.

Activation starts in one of two ways: a host write of a request bit, or an indication that the far end is sending INFO 1. The request bit clears itself at the frame boundary that samples it. The controller enters the operational state once the received INFO 3 indication has been seen on a programmable number of consecutive frame boundaries. It falls back to idle in two cases: after a programmable number of consecutive frames with no received signal, or at the frame boundary after a host deactivate request. All state changes happen on frame boundaries. A registered `activated` flag reports the operational state.

Top module: `nt_activation_ctrl`

## Requirements
- R1: After reset the state is idle (`tx_state`=0), `activated`=0, `act_req_bit`=0 and `tx_bit`=1.
- R2: In idle (`tx_state`=0) `tx_bit` is 1 for every slot code 0..7 and any channel data.
- R3: In wake-up (`tx_state`=1) `tx_bit` is 0 for every slot code 0..7, whatever the channel data.
- R4: In operational (`tx_state`=2), slot codes 0,1,2,3 (B1,B2,D,E) output `b1_bit`,`b2_bit`,`d_bit`,`e_bit` respectively, code 4 (A bit) outputs 1, and codes 5..7 output 0.
- R5: In idle, a frame boundary (`frame_start`=1) moves the state to wake-up if the request bit is set or being written, or if `rx_info`=1 (INFO 1 received).
- R6: `act_req_wr`=1 sets `act_req_bit`. Every frame boundary clears it, whether or not it caused a transition.
- R7: In wake-up, the state becomes operational at the frame boundary where `rx_info`=2 (INFO 3) has been sampled on `act_frames` consecutive boundaries. Any other value restarts the count. `act_frames`=0 behaves as 1.
- R8: In operational, the state returns to idle at the frame boundary where `rx_info`=0 (no signal) has been sampled on `los_frames` consecutive boundaries. Any other value restarts the count. `los_frames`=0 behaves as 1.
- R9: A `deact_req` pulse is held until the next frame boundary, which forces idle. It takes priority over every other cause.
- R10: `activated` is 1 exactly when the state is operational. It and `tx_state` change only on the clock edge that samples `frame_start`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame boundary strobe from the framer |
| slot_sel | input | 3 | Bit slot being requested: 0 B1, 1 B2, 2 D, 3 E, 4 A, 5..7 framing |
| b1_bit | input | 1 | B1 channel data bit |
| b2_bit | input | 1 | B2 channel data bit |
| d_bit | input | 1 | D channel data bit |
| e_bit | input | 1 | E (echo) channel data bit |
| rx_info | input | 2 | Decoded received state: 0 none, 1 INFO 1, 2 INFO 3, 3 other |
| act_req_wr | input | 1 | Host write of one to the activation request bit |
| deact_req | input | 1 | Host deactivate request pulse |
| act_frames | input | CNT_W | Consecutive INFO 3 frames needed to go operational |
| los_frames | input | CNT_W | Consecutive silent frames needed to drop to idle |
| tx_bit | output | 1 | Symbol value for the requested slot |
| tx_state | output | 2 | Transmit state: 0 INFO 0, 1 INFO 2, 2 INFO 4 |
| act_req_bit | output | 1 | Current value of the activation request bit |
| activated | output | 1 | Registered operational flag |

## Verification
The hardest conditions to reach are the ones inside the run-length windows. Examples are a break in the INFO 3 run one frame before the threshold, or a silent run cut short while operational. Neither is visible at the ports until the threshold frame arrives. The bench therefore walks each threshold value from 1 upward. It checks that the state still holds after exactly one frame fewer than needed, and that it moves on the next frame. It also plays interrupted runs that must restart the count. Each state is swept over all eight slot codes and all sixteen data patterns.

// File: rtl/nt_act_pkg.sv
package nt_act_pkg;

  typedef enum logic [1:0] {
    TX_INFO0 = 2'd0,
    TX_INFO2 = 2'd1,
    TX_INFO4 = 2'd2
  } tx_state_e;

  typedef enum logic [1:0] {
    RX_NONE  = 2'd0,
    RX_INFO1 = 2'd1,
    RX_INFO3 = 2'd2,
    RX_OTHER = 2'd3
  } rx_ind_e;

  localparam logic [2:0] SLOT_A = 3'd4;

  // data = {e, d, b2, b1}
  function automatic logic slot_symbol(tx_state_e st, logic [2:0] slot, logic [3:0] data);
    logic v;
    if (st == TX_INFO0)       v = 1'b1;
    else if (slot < 3'd4)     v = (st == TX_INFO4) ? data[slot[1:0]] : 1'b0;
    else if (slot == SLOT_A)  v = (st == TX_INFO4);
    else                      v = 1'b0;
    return v;
  endfunction

endpackage

// File: rtl/nt_act_runlen.sv
module nt_act_runlen #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             clear,
  input  logic             qualify,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);

  logic [CNT_W-1:0] cnt_q;

  function automatic logic reached(logic [CNT_W-1:0] c, logic [CNT_W-1:0] lim);
    logic [CNT_W:0] nxt;
    logic [CNT_W:0] eff;
    nxt = {1'b0, c} + 1'b1;
    eff = (lim == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, lim};
    return nxt >= eff;
  endfunction

  assign hit = frame_start && !clear && qualify && reached(cnt_q, limit);

  always_ff @(posedge clk) begin
    if (!rst_n || clear)   cnt_q <= '0;
    else if (frame_start) begin
      if (!qualify || hit) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_run_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !qualify) |=> (cnt_q == '0));

endmodule

// File: rtl/nt_act_fsm.sv
module nt_act_fsm
  import nt_act_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      frame_start,
  input  logic      deact_now,
  input  logic      req_now,
  input  rx_ind_e   rx_ind,
  input  logic      act_hit,
  input  logic      los_hit,
  output tx_state_e state,
  output logic      activated
);

  tx_state_e state_d;

  always_comb begin
    state_d = state;
    if (frame_start) begin
      if (deact_now) state_d = TX_INFO0;
      else begin
        unique case (state)
          TX_INFO0: if (req_now || rx_ind == RX_INFO1) state_d = TX_INFO2;
          TX_INFO2: if (act_hit) state_d = TX_INFO4;
          TX_INFO4: if (los_hit) state_d = TX_INFO0;
          default:  state_d = TX_INFO0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= TX_INFO0;
      activated <= 1'b0;
    end else begin
      state <= state_d;
      if (frame_start) activated <= (state_d == TX_INFO4);
    end
  end

  assert_edge_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state != $past(state) || activated != $past(activated)) |-> $past(frame_start));

  assert_rise_needs_info3_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(activated) |-> ($past(rx_ind) == RX_INFO3 && $past(state) == TX_INFO2));

  assert_drop_needs_silence_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_INFO0 && $past(state) == TX_INFO4 && !$past(deact_now))
      |-> $past(rx_ind) == RX_NONE);

  assert_deact_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && deact_now) |=> (state == TX_INFO0 && !activated));

endmodule

// File: rtl/nt_act_symbol.sv
module nt_act_symbol
  import nt_act_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  tx_state_e state,
  input  logic [2:0] slot_sel,
  input  logic [3:0] chan_data,
  output logic      tx_bit
);

  assign tx_bit = slot_symbol(state, slot_sel, chan_data);

  assert_idle_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_INFO0) |-> tx_bit);

  assert_wake_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_INFO2) |-> !tx_bit);

  assert_abit_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_INFO4 && slot_sel == SLOT_A) |-> tx_bit);

endmodule

// File: rtl/nt_activation_ctrl.sv
module nt_activation_ctrl
  import nt_act_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic [2:0]       slot_sel,
  input  logic             b1_bit,
  input  logic             b2_bit,
  input  logic             d_bit,
  input  logic             e_bit,
  input  logic [1:0]       rx_info,
  input  logic             act_req_wr,
  input  logic             deact_req,
  input  logic [CNT_W-1:0] act_frames,
  input  logic [CNT_W-1:0] los_frames,
  output logic             tx_bit,
  output logic [1:0]       tx_state,
  output logic             act_req_bit,
  output logic             activated
);

  logic      req_q, deact_q;
  logic      req_now, deact_now;
  logic      act_hit, los_hit;
  rx_ind_e   rx_ind;
  tx_state_e state;

  assign rx_ind    = rx_ind_e'(rx_info);
  assign req_now   = req_q | act_req_wr;
  assign deact_now = deact_q | deact_req;

  // host request bits: consumed at every frame boundary
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      deact_q <= 1'b0;
    end else if (frame_start) begin
      req_q   <= 1'b0;
      deact_q <= 1'b0;
    end else begin
      req_q   <= req_now;
      deact_q <= deact_now;
    end
  end

  nt_act_runlen #(.CNT_W(CNT_W)) act_run_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .clear(state != TX_INFO2), .qualify(rx_ind == RX_INFO3),
    .limit(act_frames), .hit(act_hit)
  );

  nt_act_runlen #(.CNT_W(CNT_W)) los_run_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .clear(state != TX_INFO4), .qualify(rx_ind == RX_NONE),
    .limit(los_frames), .hit(los_hit)
  );

  nt_act_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .deact_now(deact_now), .req_now(req_now), .rx_ind(rx_ind),
    .act_hit(act_hit), .los_hit(los_hit),
    .state(state), .activated(activated)
  );

  nt_act_symbol sym_i (
    .clk(clk), .rst_n(rst_n), .state(state), .slot_sel(slot_sel),
    .chan_data({e_bit, d_bit, b2_bit, b1_bit}), .tx_bit(tx_bit)
  );

  assign tx_state    = state;
  assign act_req_bit = req_q;

  assert_req_selfclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !act_req_bit);

  assert_wake_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_INFO2 && $past(state) == TX_INFO0)
      |-> ($past(req_now) || $past(rx_ind) == RX_INFO1));

  assert_flag_tracks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    activated == (state == TX_INFO4));

endmodule

// File: tb/nt_activation_ctrl_tb_top.sv
`timescale 1ns/1ps
module nt_activation_ctrl_tb_top;

  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic [2:0] slot_sel = 3'd0;
  logic b1_bit = 1'b0, b2_bit = 1'b0, d_bit = 1'b0, e_bit = 1'b0;
  logic [1:0] rx_info = 2'd0;
  logic act_req_wr = 1'b0, deact_req = 1'b0;
  logic [CNT_W-1:0] act_frames = 4'd1, los_frames = 4'd1;
  logic tx_bit, act_req_bit, activated;
  logic [1:0] tx_state;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  nt_activation_ctrl #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .slot_sel(slot_sel),
    .b1_bit(b1_bit), .b2_bit(b2_bit), .d_bit(d_bit), .e_bit(e_bit),
    .rx_info(rx_info), .act_req_wr(act_req_wr), .deact_req(deact_req),
    .act_frames(act_frames), .los_frames(los_frames), .tx_bit(tx_bit),
    .tx_state(tx_state), .act_req_bit(act_req_bit), .activated(activated)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic frame(input logic [1:0] rx);
    rx_info = rx;
    frame_start = 1'b1;
    tick();
    frame_start = 1'b0;
  endtask

  task automatic check_state(input int exp_st, input string req);
    check(tx_state == exp_st[1:0], req, tx_state, exp_st);
    check(activated == (exp_st == 2), {req, " flag"}, activated, exp_st == 2);
  endtask

  function automatic logic model_bit(int st, int slot, int data);
    if (st == 0) return 1'b1;
    if (slot < 4) return (st == 2) ? data[slot] : 1'b0;
    if (slot == 4) return st == 2;
    return 1'b0;
  endfunction

  task automatic sweep(input int st, input string req);
    for (int s = 0; s < 8; s++) begin
      for (int d = 0; d < 16; d++) begin
        slot_sel = s[2:0];
        {e_bit, d_bit, b2_bit, b1_bit} = d[3:0];
        #1;
        check(tx_bit == model_bit(st, s, d), req, tx_bit, model_bit(st, s, d));
      end
    end
    slot_sel = 3'd0;
  endtask

  task automatic pulse_req();
    act_req_wr = 1'b1; tick(); act_req_wr = 1'b0;
  endtask

  task automatic pulse_deact();
    deact_req = 1'b1; tick(); deact_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check_state(0, "R1");
    check(act_req_bit == 1'b0, "R1 req", act_req_bit, 0);
    #1 check(tx_bit == 1'b1, "R1 tx", tx_bit, 1);
    sweep(0, "R2");

    // R5/R6 host request
    pulse_req();
    check(act_req_bit == 1'b1, "R6 set", act_req_bit, 1);
    check_state(0, "R10 no frame");
    frame(2'd0);
    check_state(1, "R5 host");
    check(act_req_bit == 1'b0, "R6 clear", act_req_bit, 0);
    sweep(1, "R3");

    // R7 thresholds 1..4
    for (int L = 1; L <= 4; L++) begin
      act_frames = L[CNT_W-1:0];
      for (int k = 0; k < L - 1; k++) frame(2'd2);
      check_state(1, "R7 below");
      frame(2'd2);
      check_state(2, "R7 reach");
      if (L == 1) sweep(2, "R4");
      pulse_deact();
      check_state(2, "R9 wait");
      frame(2'd2);
      check_state(0, "R9 deact");
      frame(2'd1);
      check_state(1, "R5 info1");
    end

    // R7 interrupted run
    act_frames = 4'd3;
    frame(2'd2); frame(2'd2); frame(2'd0); frame(2'd2); frame(2'd2);
    check_state(1, "R7 restart");
    frame(2'd2);
    check_state(2, "R7 after restart");

    // R7 limit zero
    pulse_deact(); frame(2'd2); frame(2'd1);
    act_frames = 4'd0;
    frame(2'd2);
    check_state(2, "R7 zero");

    // R8 loss thresholds 1..3
    act_frames = 4'd1;
    for (int M = 1; M <= 3; M++) begin
      los_frames = M[CNT_W-1:0];
      for (int k = 0; k < M - 1; k++) frame(2'd0);
      check_state(2, "R8 below");
      frame(2'd0);
      check_state(0, "R8 reach");
      frame(2'd1); frame(2'd2);
      check_state(2, "R8 reactivate");
    end

    // R8 interrupted silence
    los_frames = 4'd2;
    frame(2'd0); frame(2'd2); frame(2'd0);
    check_state(2, "R8 restart");
    frame(2'd0);
    check_state(0, "R8 after restart");

    // R8 limit zero
    frame(2'd1); frame(2'd2);
    los_frames = 4'd0;
    frame(2'd0);
    check_state(0, "R8 zero");

    // R9 priority over host request and INFO1 in idle
    pulse_req(); pulse_deact();
    frame(2'd1);
    check_state(0, "R9 priority");
    check(act_req_bit == 1'b0, "R6 consumed", act_req_bit, 0);

    // R6 request while operational is consumed without effect
    los_frames = 4'd1;
    frame(2'd1); frame(2'd2);
    pulse_req();
    frame(2'd2);
    check_state(2, "R6 no effect");
    check(act_req_bit == 1'b0, "R6 run clear", act_req_bit, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule